// File: doc/BRIEF.md
# Internal Oscillator Rate Selector

This block picks the running rate of an internal oscillator block. It works in the domain of the 16 MHz high-frequency clock. It also takes a second, nominally 31 kHz low-frequency oscillator, which reaches it as a one-cycle tick input. Every rate is an enable pulse, one clock cycle wide, on the 16 MHz clock. A single free-running 9-bit counter produces the divided rates from 16 MHz down to 31.25 kHz.

A 3-bit rate code selects the rate, and a source bit applies only at the slowest code. The code and the source bit sit in a small configuration register, which loads when a write strobe is high. At the slowest code the source bit chooses between two sources: the divide-by-512 tap of the counter, or the low-frequency tick. A second output always carries the low-frequency tick, for watchdog-style consumers, whatever the configuration is.

Top module: `intosc_rate_sel`

## Requirements
- R1: After reset the rate code is 3 (1 MHz) and the source bit is 0. Until the next write, `rateEn` pulses exactly once every 16 cycles, and both outputs read 0 in the first cycle after reset.
- R2: For a rate code c from 1 to 7, `rateEn` pulses once every 2^(7-c) cycles. Code 7 pulses every cycle; code 1 pulses every 64 cycles.
- R3: With code 0 and the source bit at 1, `rateEn` pulses once every 512 cycles, in the cycle after the divider counter reaches all ones.
- R4: With code 0 and the source bit at 0, `rateEn` equals `lfTick` delayed by one cycle.
- R5: For any nonzero code, the source bit has no effect on `rateEn`.
- R6: `wdtTick` always equals `lfTick` delayed by one cycle, whatever the code or source bit.
- R7: The code and source bit load from `cfgRate`/`cfgHfLow` only on a cycle where `cfgWe` is 1. Changes on those inputs while `cfgWe` is 0 have no effect.
- R8: A new code takes effect at once. The `rateEn` value registered at the edge after the loading edge already follows the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz high-frequency clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRate | input | 3 | Rate code to load |
| cfgHfLow | input | 1 | Source bit to load: 1 = divided high-frequency tap at code 0 |
| lfTick | input | 1 | One-cycle tick from the low-frequency oscillator |
| rateEn | output | 1 | Selected-rate enable pulse |
| wdtTick | output | 1 | Low-frequency tick for watchdog-type consumers |

## Verification
The bench sweeps every code against both source-bit values and counts pulses over a 2048-cycle window. The window is a whole number of counter periods, so each divided rate has one exact count. A decode that is off by one tap would show a count doubled or halved. A design that lets the source bit leak into nonzero codes, or into the watchdog output, would make the tick count or the tap count appear where the other belongs. Further checks cover the reset default (a wrong reset code shows up as a count other than 128), writes without the strobe (a design that ignores the strobe would change rate), and the first cycles after a code change (a design with extra latency would miss the immediate pulse).

// File: rtl/oscsel_pkg.sv
package oscsel_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_TAPS  = NUM_CODES;        // taps 0..NUM_TAPS-2 fast, last tap slowest
  localparam int CNT_W     = 9;                // slowest tap divides by 2**CNT_W
  localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(3);

  // strobes from control to datapath: one-hot tap choice or low-frequency pass-through
  typedef struct packed {
    logic [NUM_TAPS-1:0] tapSel;
    logic                useLf;
  } oscStrobe_t;
endpackage

// File: rtl/oscsel_ctrl.sv
module oscsel_ctrl
  import oscsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgRate,
  input  logic              cfgHfLow,
  output logic [CODE_W-1:0] curCode,
  output logic              curHfLow,
  output oscStrobe_t        strobe
);
  logic [CODE_W-1:0] tapIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCode  <= RESET_CODE;
      curHfLow <= 1'b0;
    end else if (cfgWe) begin
      curCode  <= cfgRate;
      curHfLow <= cfgHfLow;
    end
  end

  // highest code maps to tap 0 (divide by 1), code 1 to tap NUM_TAPS-2
  assign tapIdx = CODE_W'(NUM_CODES - 1) - curCode;

  always_comb begin
    strobe.tapSel = '0;
    strobe.useLf  = 1'b0;
    if (curCode == '0) begin
      if (curHfLow) strobe.tapSel[NUM_TAPS-1] = 1'b1;
      else          strobe.useLf              = 1'b1;
    end else begin
      strobe.tapSel[tapIdx] = 1'b1;
    end
  end
endmodule

// File: rtl/oscsel_div.sv
module oscsel_div
  import oscsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  oscStrobe_t       strobe,
  input  logic             lfTick,
  output logic [CNT_W-1:0] divCnt,
  output logic             rateEn,
  output logic             wdtTick
);
  logic [NUM_TAPS-1:0] tapHit;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < NUM_TAPS - 1; k++) begin : g_fast
      if (k == 0) begin : g_every
        assign tapHit[k] = 1'b1;
      end else begin : g_div
        assign tapHit[k] = &divCnt[k-1:0];
      end
    end
  endgenerate
  assign tapHit[NUM_TAPS-1] = &divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateEn  <= 1'b0;
      wdtTick <= 1'b0;
    end else begin
      rateEn  <= (|(strobe.tapSel & tapHit)) | (strobe.useLf & lfTick);
      wdtTick <= lfTick;
    end
  end
endmodule

// File: rtl/intosc_rate_sel.sv
module intosc_rate_sel
  import oscsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgRate,
  input  logic              cfgHfLow,
  input  logic              lfTick,
  output logic              rateEn,
  output logic              wdtTick
);
  oscStrobe_t        strobe;
  logic [CODE_W-1:0] curCode;
  logic              curHfLow;
  logic [CNT_W-1:0]  divCnt;

  oscsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRate(cfgRate), .cfgHfLow(cfgHfLow),
    .curCode(curCode), .curHfLow(curHfLow), .strobe(strobe)
  );

  oscsel_div u_div (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lfTick(lfTick),
    .divCnt(divCnt), .rateEn(rateEn), .wdtTick(wdtTick)
  );
endmodule

// File: rtl/oscsel_chk.sv
module oscsel_chk
  import oscsel_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [CODE_W-1:0] cfgRate,
  input logic              lfTick,
  input logic [CODE_W-1:0] curCode,
  input logic              curHfLow,
  input logic [CNT_W-1:0]  divCnt,
  input logic              rateEn,
  input logic              wdtTick
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (curCode == RESET_CODE && !curHfLow)); // R1

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(curCode) == CODE_W'(NUM_CODES - 1)) |-> rateEn); // R2

  AST_DIV512_TAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(curCode) == '0 && $past(curHfLow))
      |-> (rateEn == ($past(divCnt) == '1))); // R3

  AST_LF_ROUTED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(curCode) == '0 && !$past(curHfLow))
      |-> (rateEn == $past(lfTick))); // R4

  AST_WDT_FOLLOWS_LF: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (wdtTick == $past(lfTick))); // R6

  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cfgWe)) |-> ($stable(curCode) && $stable(curHfLow))); // R7

  AST_LOAD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgWe)) |-> (curCode == $past(cfgRate))); // R7
endmodule

bind intosc_rate_sel oscsel_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRate(cfgRate), .lfTick(lfTick),
  .curCode(curCode), .curHfLow(curHfLow), .divCnt(divCnt),
  .rateEn(rateEn), .wdtTick(wdtTick)
);

// File: tb/intosc_rate_sel_tb.sv
module intosc_rate_sel_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [2:0] cfgRate = 3'd0;
  logic       cfgHfLow = 1'b0;
  logic       lfTick = 1'b0;
  logic       rateEn;
  logic       wdtTick;
  int         tests = 0;
  int         fails = 0;
  int         nRate;
  int         nWdt;

  localparam int WIN    = 2048;  // multiple of the 512-cycle counter period
  localparam int LF_CNT = 7;     // lfTick pulses at window cycles 100, 400, ... 1900

  always #10 clk = ~clk;

  intosc_rate_sel u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRate(cfgRate), .cfgHfLow(cfgHfLow),
    .lfTick(lfTick), .rateEn(rateEn), .wdtTick(wdtTick)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [2:0] code, input logic hf);
    @(negedge clk);
    cfgRate = code; cfgHfLow = hf; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic measure();
    repeat (20) @(negedge clk);
    nRate = 0; nWdt = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      nRate += int'(rateEn);
      nWdt  += int'(wdtTick);
      lfTick = ((i % 300) == 100);
    end
    lfTick = 1'b0;
  endtask

  function automatic int expRate(input int c, input int hf);
    if (c == 0) return (hf != 0) ? WIN / 512 : LF_CNT;
    return WIN >> (7 - c);
  endfunction

  initial begin
    #4000000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rateEn after reset", int'(rateEn), 0);
    chk("R1 wdtTick after reset", int'(wdtTick), 0);
    measure();
    chk("R1 default rate count", nRate, 128);
    chk("R6 wdt count at default", nWdt, LF_CNT);

    // sweep every code and both source-bit values
    for (int c = 0; c < 8; c++) begin
      for (int hf = 0; hf < 2; hf++) begin
        wrCfg(3'(c), 1'(hf));
        measure();
        if (c == 0 && hf == 1)      chk("R3 div512 tap count", nRate, expRate(c, hf));
        else if (c == 0)            chk("R4 lf routed count", nRate, expRate(c, hf));
        else if (hf == 1)           chk("R5 source bit ignored", nRate, expRate(c, hf));
        else                        chk("R2 divided rate count", nRate, expRate(c, hf));
        chk("R6 wdt count in sweep", nWdt, LF_CNT);
      end
    end

    // inputs without write strobe have no effect
    wrCfg(3'd7, 1'b0);
    @(negedge clk);
    cfgRate = 3'd0; cfgHfLow = 1'b1;
    measure();
    chk("R7 unstrobed write ignored", nRate, WIN);

    // immediate effect of a new code
    wrCfg(3'd1, 1'b0);
    repeat (5) @(negedge clk);
    cfgRate = 3'd7; cfgHfLow = 1'b0; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
    chk("R8 first pulse after switch up", int'(rateEn), 1);
    @(negedge clk);
    chk("R8 second pulse after switch up", int'(rateEn), 1);
    cfgRate = 3'd0; cfgHfLow = 1'b0; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
    chk("R8 no pulse after switch to lf", int'(rateEn), 0);

    // reset in mid-run restores the default
    wrCfg(3'd7, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    measure();
    chk("R1 default after second reset", nRate, 128);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule